// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a synthesizable slave for a two-wire serial memory holding 128 bytes, grouped into 32 rows of 4 bytes. A fast system clock samples the serial clock and data lines and detects start and stop conditions. The slave takes part in the bus only by pulling the data line low. The first byte after a start carries a 7-bit word address in its upper bits and a direction flag in bit 0. A flag of 0 opens a write and a flag of 1 opens a read. No separate device-address byte is used.

A write accepts data bytes into a small row buffer. Only the two low address bits advance, so the row stays fixed. A stop that follows at least one data byte starts a self-timed write cycle lasting a programmable number of system clocks. While that cycle runs, the slave acknowledges nothing, so a master can poll with a start and an address byte until it gets an acknowledge. The buffered bytes reach the array when the cycle ends. A read sends bytes MSB first and advances the full address after each byte the master acknowledges.

Top module: `twoWireEeprom`

## Requirements
- R1: After reset the slave does not pull SDA low, and every array byte reads as 0x00.
- R2: When no write cycle is running, the slave acknowledges the address byte (address in bits 7:1, direction in bit 0) by pulling SDA low during the ninth SCL clock.
- R3: In a write, every received data byte is acknowledged during its ninth clock.
- R4: After each write data byte only address bits 1:0 advance, and bits 6:2 are kept. A fifth byte therefore lands on the first byte position of the same row and overwrites it.
- R5: A stop after one or more write data bytes starts a write cycle of WR_CYCLES system clocks. During that cycle no address byte is acknowledged, whether it opens a read or a write. The next address byte after the cycle ends is acknowledged.
- R6: Buffered write bytes reach the array only when the write cycle ends. A start that arrives before the stop drops them and starts no write cycle.
- R7: In a read, data bits are sent MSB first, one per SCL clock. The data line changes only after an SCL falling edge.
- R8: When the master acknowledges a read byte, the full 7-bit address advances and the next byte follows. Address 127 is followed by address 0.
- R9: A master no-acknowledge on the ninth clock ends the read. The slave then leaves SDA released until the next start.
- R10: A start in any state, including part way through a byte, restarts address reception from bit 0.
- R11: sdaOe changes only in the cycle after a detected SCL falling edge, start or stop.
- R12: A write that ends with a stop right after the address byte starts no write cycle. The next address byte is acknowledged at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin (wired level) |
| sdaOe | output | 1 | High pulls the data line low; low releases it |

## Verification
The hardest case to reach is the edge of the write cycle. The cycle cannot be seen at the ports except through missing acknowledges, and its length only shows up as the point where polling starts to succeed. The stimulus sends one poll of each direction right after the stop, and one more poll timed so that its address decision falls shortly before the cycle ends. It then sends a poll after the cycle ends and expects an acknowledge and the new data. A second hard case is the dropped row buffer. A repeated start is placed directly after an acknowledged data byte. A read then follows at once, which shows both that no cycle started and that the old byte is unchanged. The array is read again after a long wait to confirm that nothing was committed late.

// File: rtl/twoWireEepromPkg.sv
package twoWireEepromPkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_WDATA = 2'd2,
    ST_RDATA = 2'd3
  } busStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic              loadAddr;
    logic              pushByte;
    logic              incRead;
    logic              clearBuf;
    logic              startCommit;
    logic [BYTE_W-1:0] byteVal;
  } strobeT;

endpackage

// File: rtl/twoWireEepromData.sv
module twoWireEepromData
  import twoWireEepromPkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int PAGE_W    = 2,
  parameter int WR_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  output logic [BYTE_W-1:0] rdByte,
  output logic              busy
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [ADDR_W-1:0] wordAddr;
  logic [BYTE_W-1:0] memArr [DEPTH];
  logic [BYTE_W-1:0] slotData [SLOTS];
  logic              slotValid [SLOTS];
  logic [CNT_W-1:0]  busyCnt;
  logic [PAGE_W-1:0] lowIdx;
  logic [ROW_W-1:0]  rowIdx;
  logic              commitNow;
  logic              anyValid;

  assign lowIdx    = wordAddr[PAGE_W-1:0];
  assign rowIdx    = wordAddr[ADDR_W-1:PAGE_W];
  assign busy      = (busyCnt != '0);
  assign commitNow = (busyCnt == CNT_W'(1));
  assign rdByte    = memArr[wordAddr];

  always_comb begin
    anyValid = 1'b0;
    for (int s = 0; s < SLOTS; s++) anyValid = anyValid | slotValid[s];
  end

  // one row-buffer slot per low-address value
  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    logic [BYTE_W-1:0] dataQ;
    logic              validQ;
    logic              hit;
    assign hit = strobe.pushByte && (lowIdx == PAGE_W'(s));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ  <= '0;
        validQ <= 1'b0;
      end else begin
        if (hit) dataQ <= strobe.byteVal;
        if (commitNow) validQ <= 1'b0;
        else if (strobe.clearBuf && !busy) validQ <= 1'b0;
        else if (hit) validQ <= 1'b1;
      end
    end
    assign slotData[s]  = dataQ;
    assign slotValid[s] = validQ;
  end

  // word address: row-local advance on write, full advance on read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddr <= '0;
    end else if (strobe.loadAddr) begin
      wordAddr <= strobe.byteVal[ADDR_W:1];
    end else if (strobe.pushByte) begin
      wordAddr <= {rowIdx, lowIdx + PAGE_W'(1)};
    end else if (strobe.incRead) begin
      wordAddr <= wordAddr + ADDR_W'(1);
    end
  end

  // self-timed write cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - CNT_W'(1);
    end else if (strobe.startCommit && anyValid) begin
      busyCnt <= CNT_W'(WR_CYCLES);
    end
  end

  // storage array, written from the row buffer at cycle end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '0;
    end else if (commitNow) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (slotValid[s]) memArr[{rowIdx, PAGE_W'(s)}] <= slotData[s];
      end
    end
  end

  // R4: row bits are kept across a write data byte
  p_row_fixed_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushByte |=> wordAddr[ADDR_W-1:PAGE_W] == $past(wordAddr[ADDR_W-1:PAGE_W]));

  // R6: a write cycle begins only on a stop strobe
  p_busy_origin_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strobe.startCommit));

  // R8: read address wraps from the top to zero
  p_read_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incRead && wordAddr == '1) |=> wordAddr == '0);

endmodule

// File: rtl/twoWireEepromCtrl.sv
module twoWireEepromCtrl
  import twoWireEepromPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rdByte,
  output strobeT            strobe,
  output logic              sdaOe
);

  localparam int SYNC_N = 2;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_N-1:0] sclSync, sdaSync;
  logic              sclPrev, sdaPrev, sclNow, sdaNow;
  logic              sclRise, sclFall, startDet, stopDet;
  busStateT          state;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg, rxByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_N-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_N-2:0], sdaIn};
      sclPrev <= sclSync[SYNC_N-1];
      sdaPrev <= sdaSync[SYNC_N-1];
    end
  end

  assign sclNow   = sclSync[SYNC_N-1];
  assign sdaNow   = sdaSync[SYNC_N-1];
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign rxByte   = {shiftReg[BYTE_W-2:0], sdaNow};

  always_comb begin
    strobe         = '0;
    strobe.byteVal = rxByte;
    if (startDet) begin
      strobe.clearBuf = 1'b1;
    end else if (stopDet) begin
      strobe.startCommit = (state == ST_WDATA);
    end else if (sclRise) begin
      unique case (state)
        ST_ADDR:  strobe.loadAddr = (bitCnt == LAST_BIT) && !busy;
        ST_WDATA: strobe.pushByte = (bitCnt == LAST_BIT);
        ST_RDATA: strobe.incRead  = (bitCnt == ACK_SLOT) && !sdaNow;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      sdaOe    <= 1'b0;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else begin
      if (sclRise && state != ST_IDLE) begin
        if (bitCnt != ACK_SLOT) shiftReg <= rxByte;
        bitCnt <= (bitCnt == ACK_SLOT) ? '0 : bitCnt + CNT_W'(1);
        unique case (state)
          ST_ADDR: begin
            if (bitCnt == LAST_BIT && busy) state <= ST_IDLE;
            else if (bitCnt == ACK_SLOT) state <= shiftReg[0] ? ST_RDATA : ST_WDATA;
          end
          ST_RDATA: if (bitCnt == ACK_SLOT && sdaNow) state <= ST_IDLE;
          default: ;
        endcase
      end
      if (sclFall) begin
        unique case (state)
          ST_ADDR, ST_WDATA: sdaOe <= (bitCnt == ACK_SLOT);
          ST_RDATA: sdaOe <= (bitCnt != ACK_SLOT) && !rdByte[~bitCnt[2:0]];
          default:  sdaOe <= 1'b0;
        endcase
      end
    end
  end

  // R11: the pull-down moves only after a clock fall, start or stop
  p_oe_timing_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> $past(sclFall || startDet || stopDet));

  // R5: silent on the bus for the whole write cycle
  p_quiet_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  // R10: a start always returns to address bit 0
  p_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR) && (bitCnt == '0));

endmodule

// File: rtl/twoWireEeprom.sv
module twoWireEeprom
  import twoWireEepromPkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int PAGE_W    = 2,
  parameter int WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  strobeT            strobe;
  logic [BYTE_W-1:0] rdByte;
  logic              busy;

  twoWireEepromCtrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .busy   (busy),
    .rdByte (rdByte),
    .strobe (strobe),
    .sdaOe  (sdaOe)
  );

  twoWireEepromData #(
    .ADDR_W    (ADDR_W),
    .PAGE_W    (PAGE_W),
    .WR_CYCLES (WR_CYCLES)
  ) data_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdByte (rdByte),
    .busy   (busy)
  );

endmodule

// File: tb/twoWireEeprom_tb_top.sv
module twoWireEeprom_tb_top;

  localparam int WRC = 2000;
  localparam int Q   = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic sdaLine;
  bit   done = 1'b0;

  always #10 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  twoWireEeprom #(.WR_CYCLES(WRC)) dut_i (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (scl),
    .sdaIn (sdaLine),
    .sdaOe (sdaOe)
  );

  int nVec = 0;
  int nBad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int refMem [128];
  longint lastStop = -100000;
  logic [7:0] wq [$];

  task automatic check(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitX(input logic b, output logic got);
    sdaM = b; waitQ();
    scl = 1'b1; waitQ();
    got = sdaLine; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic startC();
    sdaM = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic stopC();
    sdaM = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output int ack);
    logic g;
    for (int i = 7; i >= 0; i--) bitX(b[i], g);
    bitX(1'b1, g);
    ack = (g == 1'b0) ? 1 : 0;
  endtask

  task automatic recvByte(input bit masterAck, output int v);
    logic g;
    logic [7:0] r;
    for (int i = 7; i >= 0; i--) begin
      bitX(1'b1, g);
      r[i] = g;
    end
    bitX(masterAck ? 1'b0 : 1'b1, g);
    v = int'(r);
  endtask

  task automatic waitIdle();
    while (cyc < lastStop + WRC + 50) @(negedge clk);
  endtask

  // reference: row buffer with wrap, committed on stop
  task automatic doWrite(input int addr, input string tag);
    int ack;
    int lo;
    int tmp [4];
    bit v [4];
    int row;
    row = addr & 'h7C;
    lo = addr & 3;
    for (int k = 0; k < 4; k++) v[k] = 1'b0;
    startC();
    sendByte({7'(addr), 1'b0}, ack);
    check(tag, ack, 1);
    for (int k = 0; k < wq.size(); k++) begin
      sendByte(wq[k], ack);
      check("R3", ack, 1);
      tmp[lo] = int'(wq[k]);
      v[lo] = 1'b1;
      lo = (lo + 1) % 4;
    end
    stopC();
    if (wq.size() > 0) begin
      for (int k = 0; k < 4; k++) if (v[k]) refMem[row + k] = tmp[k];
      lastStop = cyc;
    end
    wq.delete();
  endtask

  task automatic doRead(input int addr, input int n, input string tag);
    int ack;
    int val;
    int a;
    startC();
    sendByte({7'(addr), 1'b1}, ack);
    check(tag, ack, 1);
    a = addr;
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, val);
      check(tag, val, refMem[a]);
      a = (a + 1) % 128;
    end
    stopC();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    int ack;
    int val;
    logic g;
    for (int i = 0; i < 128; i++) refMem[i] = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: released line and cleared array
    check("R1", int'(sdaOe), 0);
    doRead(0, 1, "R1");

    // R2 / R5: byte write, then polls during the cycle
    wq.push_back(8'hA5);
    doWrite('h15, "R2");
    startC(); sendByte({7'h15, 1'b1}, ack); check("R5", ack, 0); stopC();
    startC(); sendByte({7'h15, 1'b0}, ack); check("R5", ack, 0); stopC();
    while (cyc < lastStop + WRC - 500) @(negedge clk);
    startC(); sendByte({7'h15, 1'b1}, ack); check("R5", ack, 0); stopC();
    waitIdle();
    startC(); sendByte({7'h15, 1'b1}, ack); check("R5", ack, 1);
    recvByte(1'b0, val); check("R7", val, 'hA5); stopC();

    // R4: five bytes into row 0x20 starting at 0x22
    wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33);
    wq.push_back(8'h44); wq.push_back(8'h55);
    doWrite('h22, "R2");
    waitIdle();
    doRead('h20, 4, "R4");

    // R6: repeated start before stop drops the buffer
    startC(); sendByte({7'h40, 1'b0}, ack); check("R6", ack, 1);
    sendByte(8'h99, ack); check("R3", ack, 1);
    doRead('h40, 1, "R6");
    repeat (WRC + 200) @(negedge clk);
    doRead('h40, 1, "R6");

    // R10: abort part way through an address byte
    startC();
    bitX(1'b0, g); bitX(1'b1, g); bitX(1'b0, g);
    doRead('h22, 1, "R10");

    // R8: wrap of the read address from 127 to 0
    wq.push_back(8'hC3);
    doWrite('h7F, "R2");
    waitIdle();
    wq.push_back(8'h3C);
    doWrite('h00, "R2");
    waitIdle();
    doRead('h7F, 3, "R8");

    // R9: no-acknowledge ends the read, slave stays off the line
    startC(); sendByte({7'h15, 1'b1}, ack); check("R9", ack, 1);
    recvByte(1'b0, val); check("R9", val, 'hA5);
    for (int i = 0; i < 9; i++) begin
      bitX(1'b1, g);
      check("R9", int'(g), 1);
    end
    stopC();

    // R12: address-only write starts no cycle
    startC(); sendByte({7'h10, 1'b0}, ack); check("R12", ack, 1); stopC();
    doRead('h10, 1, "R12");
    check("R11", int'(sdaOe), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule